// File: doc/BRIEF.md
# Out-of-order issue window for one execution unit

This block is the waiting area in front of a single execution unit. The decoder pushes instructions into it. Each instruction carries an opcode, a destination tag, and two source operands. A source is either already known, in which case its value is copied into the slot, or it is still being computed, in which case only the tag of its producer is kept. Because the slot keeps its own copy of every known operand, a later instruction that overwrites the architectural register cannot change what this instruction will compute with.

Completed results arrive on a tagged broadcast bus. Any slot whose missing operand is waiting on that tag takes the value and marks the operand present. A slot becomes eligible to issue once both operands are present. While the unit is not busy, the oldest eligible slot is presented on the issue port and leaves the window at that clock edge. The decision uses only this unit's own state. Nothing from other units feeds into it.

The window size and all field widths are parameters. When every slot is occupied, the full output tells the decoder to hold.

Top module: `rs_issue_window`

## Requirements
- R1: After reset, and while reset is held, the window is empty: `full` is 0 and `iss_valid` is 0, and no entry held before reset is ever issued.
- R2: An insert is taken when `ins_valid`=1 and `full`=0. `full` is 1 exactly when all NUM_ENT slots hold an entry. An insert offered while `full`=1 is dropped and never appears at the issue port.
- R3: A source inserted with its ready bit = 1 keeps the inserted value. A later broadcast whose tag equals the low bits of that value, or any other tag, does not change what is issued.
- R4: A source inserted with ready bit = 0 stores its producer tag. In a later cycle, a broadcast with `res_valid`=1 and `res_tag` equal to that tag replaces the operand with `res_val` and marks it present.
- R5: An entry with any operand still waiting on a tag is never issued. Younger entries whose operands are all present may issue ahead of it.
- R6: `iss_valid` is 0 whenever `unit_busy`=1. At most one entry issues per cycle. When `unit_busy`=0 and some entry is ready, `iss_valid` is 1 in that cycle.
- R7: Among ready entries, the one inserted earliest is issued, whichever slot index it occupies.
- R8: An entry shown with `iss_valid`=1 leaves the window at that clock edge. If the window was full, `full` is 0 in the next cycle and an insert is accepted there.
- R9: If a broadcast with a matching tag arrives in the same cycle as the insert of a waiting source, that source is stored as present with the broadcast value.
- R10: An inserted entry, or an operand captured from the broadcast, is first eligible for issue in the cycle after the capturing clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Decoder offers an instruction |
| ins_op | input | OP_W | Opcode of the offered instruction |
| ins_dst | input | TAG_W | Destination tag of the offered instruction |
| ins_a_rdy | input | 1 | 1: source A value is present, 0: waiting on `ins_a_tag` |
| ins_a_val | input | DATA_W | Source A value |
| ins_a_tag | input | TAG_W | Producer tag for source A |
| ins_b_rdy | input | 1 | 1: source B value is present, 0: waiting on `ins_b_tag` |
| ins_b_val | input | DATA_W | Source B value |
| ins_b_tag | input | TAG_W | Producer tag for source B |
| full | output | 1 | All slots occupied; the decoder must stall |
| res_valid | input | 1 | Result broadcast is valid |
| res_tag | input | TAG_W | Tag of the broadcast result |
| res_val | input | DATA_W | Broadcast result value |
| unit_busy | input | 1 | Execution unit cannot accept an instruction |
| iss_valid | output | 1 | An entry is issued this cycle |
| iss_op | output | OP_W | Opcode of the issued entry |
| iss_dst | output | TAG_W | Destination tag of the issued entry |
| iss_a | output | DATA_W | Source A operand of the issued entry |
| iss_b | output | DATA_W | Source B operand of the issued entry |

## Verification
The hardest case to reach is a slot that was freed and refilled while older entries still sit in higher-numbered slots. Only that case separates true age order from slot-index order. The stimulus fills the window while the unit is busy and drains one entry. It then inserts a new entry into the freed low slot and drains the rest, so the new entry must come out last. The same-cycle broadcast at insert and a broadcast tag that collides with an already-present value are both driven as separate steps of the table.

// File: rtl/rsw_pkg.sv
package rsw_pkg;
   // Default sizing shared by the window and its helpers.
   localparam int unsigned DEF_NUM_ENT = 4;
   localparam int unsigned DEF_DATA_W  = 16;
   localparam int unsigned DEF_TAG_W   = 4;
   localparam int unsigned DEF_OP_W    = 4;

   // Operand slot state: holding a producer tag or holding data.
   typedef enum logic {
      OPND_WAIT = 1'b0,
      OPND_HAVE = 1'b1
   } opnd_state_e;
endpackage

// File: rtl/rsw_operand.sv
// One source operand field: loads at insert, snoops the result bus while waiting.
module rsw_operand
   import rsw_pkg::*;
#(
   parameter int unsigned DATA_W = DEF_DATA_W,
   parameter int unsigned TAG_W  = DEF_TAG_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              ld_rdy,
   input  logic [DATA_W-1:0] ld_val,
   input  logic [TAG_W-1:0]  ld_tag,
   input  logic              bc_valid,
   input  logic [TAG_W-1:0]  bc_tag,
   input  logic [DATA_W-1:0] bc_val,
   output logic              rdy,
   output logic [DATA_W-1:0] val
);
   opnd_state_e        st_q;
   logic [TAG_W-1:0]   tag_q;
   logic [DATA_W-1:0]  val_q;
   logic               ld_hit;
   logic               snoop_hit;

   // R9: broadcast in the insert cycle is caught on the way in
   assign ld_hit    = bc_valid && (bc_tag == ld_tag);
   // R4: a waiting field only listens to its own producer tag
   assign snoop_hit = (st_q == OPND_WAIT) && bc_valid && (bc_tag == tag_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q  <= OPND_WAIT;
         tag_q <= '0;
         val_q <= '0;
      end else if (load) begin
         tag_q <= ld_tag;
         if (ld_rdy) begin
            st_q  <= OPND_HAVE;
            val_q <= ld_val;
         end else if (ld_hit) begin
            st_q  <= OPND_HAVE;
            val_q <= bc_val;
         end else begin
            st_q  <= OPND_WAIT;
         end
      end else if (snoop_hit) begin
         st_q  <= OPND_HAVE;
         val_q <= bc_val;
      end
   end

   assign rdy = (st_q == OPND_HAVE);
   assign val = val_q;
endmodule

// File: rtl/rsw_slot_alloc.sv
// Picks the lowest-numbered free slot as a one-hot vector.
module rsw_slot_alloc #(
   parameter int unsigned NUM_ENT = 4
) (
   input  logic [NUM_ENT-1:0] occupied,
   output logic [NUM_ENT-1:0] pick
);
   always_comb begin
      logic found;
      found = 1'b0;
      pick  = '0;
      for (int i = 0; i < NUM_ENT; i++) begin
         if (!occupied[i] && !found) begin
            pick[i] = 1'b1;
            found   = 1'b1;
         end
      end
   end
endmodule

// File: rtl/rsw_age_arb.sv
// Age matrix: older_q[j][i] = 1 means slot j was filled before slot i.
module rsw_age_arb #(
   parameter int unsigned NUM_ENT = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_ENT-1:0] alloc,
   input  logic [NUM_ENT-1:0] req,
   output logic [NUM_ENT-1:0] grant
);
   logic [NUM_ENT-1:0] older_q [NUM_ENT];

   generate
      for (genvar r = 0; r < NUM_ENT; r++) begin : g_row
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               older_q[r] <= '0;
            end else begin
               for (int c = 0; c < NUM_ENT; c++) begin
                  if (alloc[r])
                     older_q[r][c] <= 1'b0;         // newcomer is older than nobody
                  else if (alloc[c])
                     older_q[r][c] <= 1'b1;         // everyone else precedes newcomer
               end
            end
         end
      end
   endgenerate

   // R7: a requester wins when no other requester is older than it
   always_comb begin
      for (int i = 0; i < NUM_ENT; i++) begin
         logic blocked;
         blocked = 1'b0;
         for (int j = 0; j < NUM_ENT; j++) begin
            if (j != i && req[j] && older_q[j][i])
               blocked = 1'b1;
         end
         grant[i] = req[i] && !blocked;
      end
   end
endmodule

// File: rtl/rs_issue_window.sv
module rs_issue_window
   import rsw_pkg::*;
#(
   parameter int unsigned NUM_ENT = DEF_NUM_ENT,
   parameter int unsigned DATA_W  = DEF_DATA_W,
   parameter int unsigned TAG_W   = DEF_TAG_W,
   parameter int unsigned OP_W    = DEF_OP_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ins_valid,
   input  logic [OP_W-1:0]   ins_op,
   input  logic [TAG_W-1:0]  ins_dst,
   input  logic              ins_a_rdy,
   input  logic [DATA_W-1:0] ins_a_val,
   input  logic [TAG_W-1:0]  ins_a_tag,
   input  logic              ins_b_rdy,
   input  logic [DATA_W-1:0] ins_b_val,
   input  logic [TAG_W-1:0]  ins_b_tag,
   output logic              full,
   input  logic              res_valid,
   input  logic [TAG_W-1:0]  res_tag,
   input  logic [DATA_W-1:0] res_val,
   input  logic              unit_busy,
   output logic              iss_valid,
   output logic [OP_W-1:0]   iss_op,
   output logic [TAG_W-1:0]  iss_dst,
   output logic [DATA_W-1:0] iss_a,
   output logic [DATA_W-1:0] iss_b
);
   localparam int unsigned NUM_SRC = 2;

   generate
      if (NUM_ENT < 2) begin : g_bad_ent
         $error("rs_issue_window: NUM_ENT must be at least 2");
      end
      if (DATA_W < 1 || TAG_W < 1 || OP_W < 1) begin : g_bad_w
         $error("rs_issue_window: widths must be positive");
      end
   endgenerate

   logic [NUM_ENT-1:0] valid_q;
   logic [OP_W-1:0]    op_q  [NUM_ENT];
   logic [TAG_W-1:0]   dst_q [NUM_ENT];
   logic [NUM_ENT-1:0] src_rdy [NUM_SRC];
   logic [DATA_W-1:0]  src_val [NUM_SRC][NUM_ENT];
   logic [NUM_ENT-1:0] free_pick;
   logic [NUM_ENT-1:0] ins_slot;
   logic [NUM_ENT-1:0] ready;
   logic [NUM_ENT-1:0] req;
   logic [NUM_ENT-1:0] grant;
   logic               accept;

   // R2: full only when every slot holds an entry
   assign full   = &valid_q;
   assign accept = ins_valid && !full;

   rsw_slot_alloc #(.NUM_ENT(NUM_ENT)) u_alloc (
      .occupied (valid_q),
      .pick     (free_pick)
   );
   assign ins_slot = free_pick & {NUM_ENT{accept}};

   generate
      for (genvar e = 0; e < NUM_ENT; e++) begin : g_ent
         rsw_operand #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_src_a (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (ins_slot[e]),
            .ld_rdy   (ins_a_rdy),
            .ld_val   (ins_a_val),
            .ld_tag   (ins_a_tag),
            .bc_valid (res_valid),
            .bc_tag   (res_tag),
            .bc_val   (res_val),
            .rdy      (src_rdy[0][e]),
            .val      (src_val[0][e])
         );
         rsw_operand #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_src_b (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (ins_slot[e]),
            .ld_rdy   (ins_b_rdy),
            .ld_val   (ins_b_val),
            .ld_tag   (ins_b_tag),
            .bc_valid (res_valid),
            .bc_tag   (res_tag),
            .bc_val   (res_val),
            .rdy      (src_rdy[1][e]),
            .val      (src_val[1][e])
         );

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               valid_q[e] <= 1'b0;
               op_q[e]    <= '0;
               dst_q[e]   <= '0;
            end else if (ins_slot[e]) begin
               valid_q[e] <= 1'b1;
               op_q[e]    <= ins_op;
               dst_q[e]   <= ins_dst;
            end else if (grant[e]) begin
               valid_q[e] <= 1'b0;   // R8: slot freed at the issue edge
            end
         end

         // R5: all source fields must hold data
         assign ready[e] = valid_q[e] && src_rdy[0][e] && src_rdy[1][e];
      end
   endgenerate

   // R6: a busy unit suppresses every request
   assign req = ready & {NUM_ENT{!unit_busy}};

   rsw_age_arb #(.NUM_ENT(NUM_ENT)) u_arb (
      .clk   (clk),
      .rst_n (rst_n),
      .alloc (ins_slot),
      .req   (req),
      .grant (grant)
   );

   always_comb begin
      iss_valid = |grant;
      iss_op    = '0;
      iss_dst   = '0;
      iss_a     = '0;
      iss_b     = '0;
      for (int e = 0; e < NUM_ENT; e++) begin
         if (grant[e]) begin
            iss_op  = iss_op  | op_q[e];
            iss_dst = iss_dst | dst_q[e];
            iss_a   = iss_a   | src_val[0][e];
            iss_b   = iss_b   | src_val[1][e];
         end
      end
   end
endmodule

// File: rtl/rsw_checker.sv
module rsw_checker #(
   parameter int unsigned NUM_ENT = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic               ins_valid,
   input logic               full,
   input logic               unit_busy,
   input logic               iss_valid,
   input logic [NUM_ENT-1:0] valid_q,
   input logic [NUM_ENT-1:0] ready,
   input logic [NUM_ENT-1:0] grant
);
   a_r6_busy_blocks_issue: assert property (@(posedge clk) disable iff (!rst_n)
      unit_busy |-> !iss_valid);

   a_r6_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));

   a_r5_grant_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
      (grant & ~ready) == '0);

   a_r6_ready_gets_issued: assert property (@(posedge clk) disable iff (!rst_n)
      (!unit_busy && (|ready)) |-> iss_valid);

   a_r2_full_no_growth: assert property (@(posedge clk) disable iff (!rst_n)
      full |=> ($countones(valid_q) <= $past($countones(valid_q))));

   a_r8_issue_frees_slot: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_valid && !(ins_valid && !full)) |=>
         ($countones(valid_q) + 1 == $past($countones(valid_q))));
endmodule

bind rs_issue_window rsw_checker #(.NUM_ENT(NUM_ENT)) u_rsw_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .ins_valid (ins_valid),
   .full      (full),
   .unit_busy (unit_busy),
   .iss_valid (iss_valid),
   .valid_q   (valid_q),
   .ready     (ready),
   .grant     (grant)
);

// File: tb/test_rs_issue_window.sv
`timescale 1ns/1ps
module test_rs_issue_window;
   localparam int DW = 16;
   localparam int TW = 4;
   localparam int OW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ins_valid = 1'b0;
   logic [OW-1:0] ins_op = '0;
   logic [TW-1:0] ins_dst;
   logic          ins_a_rdy = 1'b0, ins_b_rdy = 1'b0;
   logic [DW-1:0] ins_a_val = '0, ins_b_val = '0;
   logic [TW-1:0] ins_a_tag, ins_b_tag;
   logic          full;
   logic          res_valid = 1'b0;
   logic [TW-1:0] res_tag = '0;
   logic [DW-1:0] res_val = '0;
   logic          unit_busy = 1'b1;
   logic          iss_valid;
   logic [OW-1:0] iss_op;
   logic [TW-1:0] iss_dst;
   logic [DW-1:0] iss_a, iss_b;

   // destination tag follows opcode, producer tags come from the low value bits
   assign ins_dst   = ins_op;
   assign ins_a_tag = ins_a_val[TW-1:0];
   assign ins_b_tag = ins_b_val[TW-1:0];

   always #2.5 clk = ~clk;

   rs_issue_window i_rs_issue_window (
      .clk(clk), .rst_n(rst_n),
      .ins_valid(ins_valid), .ins_op(ins_op), .ins_dst(ins_dst),
      .ins_a_rdy(ins_a_rdy), .ins_a_val(ins_a_val), .ins_a_tag(ins_a_tag),
      .ins_b_rdy(ins_b_rdy), .ins_b_val(ins_b_val), .ins_b_tag(ins_b_tag),
      .full(full),
      .res_valid(res_valid), .res_tag(res_tag), .res_val(res_val),
      .unit_busy(unit_busy),
      .iss_valid(iss_valid), .iss_op(iss_op), .iss_dst(iss_dst),
      .iss_a(iss_a), .iss_b(iss_b)
   );

   typedef struct packed {
      logic          iv;
      logic [3:0]    op;
      logic          ar;
      logic [15:0]   av;
      logic          br;
      logic [15:0]   bv;
      logic          rv;
      logic [3:0]    rt;
      logic [15:0]   rval;
      logic          busy;
      logic          eiv;
      logic [3:0]    eop;
      logic [15:0]   ea;
      logic [15:0]   eb;
      logic          efull;
      logic [7:0]    req;
   } vec_t;

   localparam int NV = 25;
   // per cycle: inputs, then outputs expected before the closing edge
   localparam vec_t VECS [NV] = '{
      '{1'b0,4'h0,1'b0,16'h0000,1'b0,16'h0000,1'b0,4'h0,16'h0000,1'b0, 1'b0,4'h0,16'h0000,16'h0000,1'b0, 8'd1}, // R1 empty
      '{1'b1,4'h1,1'b1,16'h0011,1'b1,16'h0022,1'b0,4'h0,16'h0000,1'b1, 1'b0,4'h0,16'h0000,16'h0000,1'b0, 8'd2}, // R2 insert
      '{1'b1,4'h2,1'b0,16'h0005,1'b1,16'h0033,1'b0,4'h0,16'h0000,1'b1, 1'b0,4'h0,16'h0000,16'h0000,1'b0, 8'd6}, // R6 busy
      '{1'b1,4'h3,1'b1,16'h0044,1'b1,16'h0055,1'b0,4'h0,16'h0000,1'b1, 1'b0,4'h0,16'h0000,16'h0000,1'b0, 8'd6},
      '{1'b0,4'h0,1'b0,16'h0000,1'b0,16'h0000,1'b0,4'h0,16'h0000,1'b0, 1'b1,4'h1,16'h0011,16'h0022,1'b0, 8'd7}, // R7 oldest
      '{1'b0,4'h0,1'b0,16'h0000,1'b0,16'h0000,1'b0,4'h0,16'h0000,1'b0, 1'b1,4'h3,16'h0044,16'h0055,1'b0, 8'd5}, // R5 skip waiter
      '{1'b0,4'h0,1'b0,16'h0000,1'b0,16'h0000,1'b1,4'h5,16'h0666,1'b0, 1'b0,4'h0,16'h0000,16'h0000,1'b0, 8'd10},// R10 not yet
      '{1'b0,4'h0,1'b0,16'h0000,1'b0,16'h0000,1'b0,4'h0,16'h0000,1'b0, 1'b1,4'h2,16'h0666,16'h0033,1'b0, 8'd4}, // R4 captured
      '{1'b1,4'h4,1'b0,16'h0007,1'b1,16'h0088,1'b1,4'h7,16'h0999,1'b0, 1'b0,4'h0,16'h0000,16'h0000,1'b0, 8'd10},// R10
      '{1'b0,4'h0,1'b0,16'h0000,1'b0,16'h0000,1'b0,4'h0,16'h0000,1'b0, 1'b1,4'h4,16'h0999,16'h0088,1'b0, 8'd9}, // R9 bypass
      '{1'b1,4'h5,1'b1,16'h0123,1'b0,16'h0009,1'b1,4'h3,16'hdead,1'b1, 1'b0,4'h0,16'h0000,16'h0000,1'b0, 8'd3}, // R3
      '{1'b0,4'h0,1'b0,16'h0000,1'b0,16'h0000,1'b1,4'h9,16'h0bbb,1'b1, 1'b0,4'h0,16'h0000,16'h0000,1'b0, 8'd4},
      '{1'b0,4'h0,1'b0,16'h0000,1'b0,16'h0000,1'b0,4'h0,16'h0000,1'b0, 1'b1,4'h5,16'h0123,16'h0bbb,1'b0, 8'd3}, // R3 copy kept
      '{1'b1,4'h6,1'b1,16'h0106,1'b1,16'h0206,1'b0,4'h0,16'h0000,1'b1, 1'b0,4'h0,16'h0000,16'h0000,1'b0, 8'd2},
      '{1'b1,4'h7,1'b1,16'h0107,1'b1,16'h0207,1'b0,4'h0,16'h0000,1'b1, 1'b0,4'h0,16'h0000,16'h0000,1'b0, 8'd2},
      '{1'b1,4'h8,1'b1,16'h0108,1'b1,16'h0208,1'b0,4'h0,16'h0000,1'b1, 1'b0,4'h0,16'h0000,16'h0000,1'b0, 8'd2},
      '{1'b1,4'h9,1'b1,16'h0109,1'b1,16'h0209,1'b0,4'h0,16'h0000,1'b1, 1'b0,4'h0,16'h0000,16'h0000,1'b0, 8'd2},
      '{1'b1,4'ha,1'b1,16'h010a,1'b1,16'h020a,1'b0,4'h0,16'h0000,1'b1, 1'b0,4'h0,16'h0000,16'h0000,1'b1, 8'd2}, // R2 dropped
      '{1'b0,4'h0,1'b0,16'h0000,1'b0,16'h0000,1'b0,4'h0,16'h0000,1'b0, 1'b1,4'h6,16'h0106,16'h0206,1'b1, 8'd7},
      '{1'b1,4'hb,1'b1,16'h010b,1'b1,16'h020b,1'b0,4'h0,16'h0000,1'b1, 1'b0,4'h0,16'h0000,16'h0000,1'b0, 8'd8}, // R8 refill
      '{1'b0,4'h0,1'b0,16'h0000,1'b0,16'h0000,1'b0,4'h0,16'h0000,1'b0, 1'b1,4'h7,16'h0107,16'h0207,1'b1, 8'd7}, // R7 age, not slot
      '{1'b0,4'h0,1'b0,16'h0000,1'b0,16'h0000,1'b0,4'h0,16'h0000,1'b0, 1'b1,4'h8,16'h0108,16'h0208,1'b0, 8'd7},
      '{1'b0,4'h0,1'b0,16'h0000,1'b0,16'h0000,1'b0,4'h0,16'h0000,1'b0, 1'b1,4'h9,16'h0109,16'h0209,1'b0, 8'd7},
      '{1'b0,4'h0,1'b0,16'h0000,1'b0,16'h0000,1'b0,4'h0,16'h0000,1'b0, 1'b1,4'hb,16'h010b,16'h020b,1'b0, 8'd2}, // R2 A gone
      '{1'b0,4'h0,1'b0,16'h0000,1'b0,16'h0000,1'b0,4'h0,16'h0000,1'b0, 1'b0,4'h0,16'h0000,16'h0000,1'b0, 8'd5}
   };

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   task automatic chk(input bit ok, input int req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL R%0d %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic idle_inputs();
      ins_valid = 1'b0; ins_op = '0; ins_a_rdy = 1'b0; ins_a_val = '0;
      ins_b_rdy = 1'b0; ins_b_val = '0; res_valid = 1'b0; res_tag = '0; res_val = '0;
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      idle_inputs();
      unit_busy = 1'b1;
      repeat (3) @(posedge clk);
      #1;
      chk(full == 1'b0, 1, "full in reset", full, 0);        // R1
      chk(iss_valid == 1'b0, 1, "iss_valid in reset", iss_valid, 0);
      @(negedge clk); rst_n = 1'b1;

      for (int v = 0; v < NV; v++) begin
         @(negedge clk);
         ins_valid = VECS[v].iv;   ins_op = VECS[v].op;
         ins_a_rdy = VECS[v].ar;   ins_a_val = VECS[v].av;
         ins_b_rdy = VECS[v].br;   ins_b_val = VECS[v].bv;
         res_valid = VECS[v].rv;   res_tag = VECS[v].rt;  res_val = VECS[v].rval;
         unit_busy = VECS[v].busy;
         #1;
         chk(iss_valid == VECS[v].eiv, int'(VECS[v].req), $sformatf("row %0d iss_valid", v),
             iss_valid, VECS[v].eiv);
         chk(full == VECS[v].efull, int'(VECS[v].req), $sformatf("row %0d full", v),
             full, VECS[v].efull);
         if (VECS[v].eiv) begin
            chk(iss_op == VECS[v].eop, int'(VECS[v].req), $sformatf("row %0d op", v), iss_op, VECS[v].eop);
            chk(iss_dst == VECS[v].eop, int'(VECS[v].req), $sformatf("row %0d dst", v), iss_dst, VECS[v].eop);
            chk(iss_a == VECS[v].ea, int'(VECS[v].req), $sformatf("row %0d a", v), iss_a, VECS[v].ea);
            chk(iss_b == VECS[v].eb, int'(VECS[v].req), $sformatf("row %0d b", v), iss_b, VECS[v].eb);
         end
      end

      // R1: reset discards held entries
      @(negedge clk);
      idle_inputs(); unit_busy = 1'b1;
      ins_valid = 1'b1; ins_op = 4'hc; ins_a_rdy = 1'b1; ins_a_val = 16'h0c0c;
      ins_b_rdy = 1'b1; ins_b_val = 16'h0d0d;
      @(negedge clk);
      idle_inputs();
      rst_n = 1'b0; unit_busy = 1'b0;
      @(negedge clk);
      chk(iss_valid == 1'b0, 1, "iss_valid after mid-run reset", iss_valid, 0);
      chk(full == 1'b0, 1, "full after mid-run reset", full, 0);
      rst_n = 1'b1;
      @(negedge clk); #1;
      chk(iss_valid == 1'b0, 1, "entry survived reset", iss_valid, 0);

      // R10 / R4: capture for a waiting B operand, then issue next cycle
      @(negedge clk);
      ins_valid = 1'b1; ins_op = 4'hd; ins_a_rdy = 1'b1; ins_a_val = 16'h00a1;
      ins_b_rdy = 1'b0; ins_b_val = 16'h0002; unit_busy = 1'b0;
      @(negedge clk);
      idle_inputs(); res_valid = 1'b1; res_tag = 4'h2; res_val = 16'hbeef; #1;
      chk(iss_valid == 1'b0, 10, "waiting entry before capture", iss_valid, 0);
      @(negedge clk);
      idle_inputs(); #1;
      chk(iss_valid == 1'b1, 10, "issue after capture", iss_valid, 1);
      chk(iss_b == 16'hbeef, 4, "captured B operand", iss_b, 16'hbeef);
      @(negedge clk); #1;
      chk(iss_valid == 1'b0, 8, "window empty after issue", iss_valid, 0);

      done = 1'b1;
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule